// File: doc/BRIEF.md
# Operand Interlock and Bypass Control

This block provides hazard control for a single-issue, in-order pipeline whose execution units have different latencies. One instruction at a time waits at the head of the execute stage. For each destination register that still has a result in flight, the block counts down the cycles until that result can first be used. It also records which unit is producing it.

In every cycle the block looks at the waiting instruction's two source registers. If either source is still counting down, the instruction cannot enter execute. The block then asserts a stall that holds every earlier stage, and it puts a bubble into execute in place of the instruction. Otherwise the instruction issues. For each operand the block reports one of two choices: take the value from the bypass slot of the unit that produces it, or read the register file.

When the instruction issues, its destination is recorded with the latency of its operation class. Latency is counted from the cycle an instruction enters execute to the first cycle a later instruction can use its result. Integer results therefore reach the very next instruction without a stall. Multiply, floating-point add and divide results hold dependents back until their ready cycle.

Top module: `hz_interlock`

## Requirements
- R1: After reset no register is in flight. A valid instruction with any sources gets stall and bubble low, and both operand selects read 0 (register file).
- R2: The operation class is encoded as integer=0, FP add=1, multiply=2, divide=3. The latencies are 1, 4, 5 and 14 cycles. An instruction issued in cycle t has its result usable from cycle t+latency. A dependent instruction presented before that cycle sees stall and bubble high.
- R3: An instruction that reads the destination of an integer instruction issued in the previous cycle issues without a stall. The operand select for that source is 1.
- R4: The operand select is encoded as register file=0, integer slot=1, FP-add slot=2, multiply slot=3, divide slot=4. A source selects its producer's slot only in the ready cycle. From the next cycle it selects 0.
- R5: Countdowns keep running while the pipeline is stalled. An instruction that is held behind an in-flight producer issues exactly in the producer's ready cycle.
- R6: Register 0 never causes a stall and always selects the register file, even if an instruction names it as a destination.
- R7: When a younger instruction writes a register that an older one still has in flight, the younger one replaces the older one. Readers then follow the younger producer's latency and slot.
- R8: Two results that become ready in the same cycle each appear on their own unit's slot. One instruction can take both in that cycle.
- R9: Only a valid instruction that issues and has its write flag set records a destination. An invalid slot never stalls. A stalled instruction records nothing. Bubble is asserted exactly when stall is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| iss_valid_i | input | 1 | An instruction waits at the head of execute |
| iss_op_i | input | 2 | Operation class of the waiting instruction |
| iss_src_a_i | input | 5 | First source register number |
| iss_src_b_i | input | 5 | Second source register number |
| iss_dst_i | input | 5 | Destination register number |
| iss_dst_wr_i | input | 1 | Waiting instruction writes its destination |
| stall_o | output | 1 | Hold all stages before execute this cycle |
| bubble_o | output | 1 | Place a no-operation into execute this cycle |
| byp_sel_a_o | output | 3 | Source of the first operand (R4 encoding) |
| byp_sel_b_o | output | 3 | Source of the second operand (R4 encoding) |

## Verification
The bench holds a dependent instruction behind multiply, FP add and divide producers and counts the stall cycles exactly. A design that freezes its countdowns during a stall would issue late. A design that is off by one in latency would bypass too early or stall once too often.

Other tests target the following faults:
- Overwriting a long divide with a younger integer write. Keeping the older producer shows up as a long stall.
- Two producers finishing in the same cycle. A shared slot shows up as a wrong select.
- Register 0 named as a destination.
- An invalid or stalled instruction that wrongly records its destination. This shows up as a false bypass on the next reader.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        OP_INT  = 2'd0,
        OP_FADD = 2'd1,
        OP_MUL  = 2'd2,
        OP_DIV  = 2'd3
    } op_class_e;

    typedef enum logic [2:0] {
        BYP_RF   = 3'd0,
        BYP_INT  = 3'd1,
        BYP_FADD = 3'd2,
        BYP_MUL  = 3'd3,
        BYP_DIV  = 3'd4
    } byp_sel_e;

    // Tag of an in-flight result: valid flag and producing unit
    typedef struct packed {
        logic      pending;
        op_class_e unit;
    } sb_tag_t;

    // Each unit has its own bypass slot
    function automatic byp_sel_e slot_of(op_class_e c);
        byp_sel_e s;
        case (c)
            OP_INT:  s = BYP_INT;
            OP_FADD: s = BYP_FADD;
            OP_MUL:  s = BYP_MUL;
            default: s = BYP_DIV;
        endcase
        return s;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hz_scoreboard.sv
module hz_scoreboard
    import hz_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int CNT_W = 4,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [CNT_W-1:0] wr_cnt_i,
    input  op_class_e        wr_unit_i,
    output sb_tag_t          tag_o [NREG],
    output logic [CNT_W-1:0] cnt_o [NREG]
);

    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_reg
            if (r == 0) begin : g_zero
                // Register 0 holds no in-flight state
                assign tag_o[r] = '0;
                assign cnt_o[r] = '0;
            end else begin : g_live
                sb_tag_t          tag_q;
                logic [CNT_W-1:0] cnt_q;
                logic             hit;

                assign hit = wr_en_i && (wr_idx_i == IDX_W'(r));

                always_ff @(posedge clk_i) begin
                    if (rst_i) begin
                        tag_q <= '0;
                        cnt_q <= '0;
                    end else if (hit) begin
                        // newest producer replaces any older one
                        tag_q.pending <= 1'b1;
                        tag_q.unit    <= wr_unit_i;
                        cnt_q         <= wr_cnt_i;
                    end else if (tag_q.pending) begin
                        if (cnt_q == '0) begin
                            tag_q.pending <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end

                assign tag_o[r] = tag_q;
                assign cnt_o[r] = cnt_q;
            end
        end
    endgenerate

endmodule

// File: rtl/hz_operand_check.sv
module hz_operand_check
    import hz_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int CNT_W = 4,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [IDX_W-1:0] idx_i,
    input  sb_tag_t          tag_i [NREG],
    input  logic [CNT_W-1:0] cnt_i [NREG],
    output logic             wait_o,
    output byp_sel_e         sel_o
);

    sb_tag_t          tag;
    logic [CNT_W-1:0] cnt;
    logic             live;

    always_comb begin
        tag  = tag_i[idx_i];
        cnt  = cnt_i[idx_i];
        live = (idx_i != '0) && tag.pending;
    end

    always_comb begin
        wait_o = live && (cnt != '0);
        sel_o  = BYP_RF;
        if (live && (cnt == '0)) begin
            sel_o = slot_of(tag.unit);
        end
    end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int LAT_INT  = 1,
    parameter int LAT_FADD = 4,
    parameter int LAT_MUL  = 5,
    parameter int LAT_DIV  = 14,
    parameter int IDX_W    = $clog2(NREG)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             iss_valid_i,
    input  logic [1:0]       iss_op_i,
    input  logic [IDX_W-1:0] iss_src_a_i,
    input  logic [IDX_W-1:0] iss_src_b_i,
    input  logic [IDX_W-1:0] iss_dst_i,
    input  logic             iss_dst_wr_i,
    output logic             stall_o,
    output logic             bubble_o,
    output logic [2:0]       byp_sel_a_o,
    output logic [2:0]       byp_sel_b_o
);

    localparam int MAX_LAT = max_of(max_of(LAT_INT, LAT_FADD), max_of(LAT_MUL, LAT_DIV));
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam int N_SRC   = 2;

    op_class_e        op;
    sb_tag_t          tag   [NREG];
    logic [CNT_W-1:0] cnt   [NREG];
    logic [IDX_W-1:0] src   [N_SRC];
    logic             waits [N_SRC];
    byp_sel_e         sel   [N_SRC];
    logic             hazard;
    logic             issue;
    logic             rec_en;
    logic [CNT_W-1:0] rec_cnt;

    assign op     = op_class_e'(iss_op_i);
    assign src[0] = iss_src_a_i;
    assign src[1] = iss_src_b_i;

    genvar s;
    generate
        for (s = 0; s < N_SRC; s++) begin : g_src
            hz_operand_check #(
                .NREG (NREG),
                .CNT_W(CNT_W),
                .IDX_W(IDX_W)
            ) u_chk (
                .idx_i (src[s]),
                .tag_i (tag),
                .cnt_i (cnt),
                .wait_o(waits[s]),
                .sel_o (sel[s])
            );
        end
    endgenerate

    assign hazard = iss_valid_i && (waits[0] || waits[1]);
    assign issue  = iss_valid_i && !hazard;
    assign rec_en = issue && iss_dst_wr_i && (iss_dst_i != '0);

    // countdown starts one below latency: reaches zero in the ready cycle
    always_comb begin
        case (op)
            OP_INT:  rec_cnt = CNT_W'(LAT_INT - 1);
            OP_FADD: rec_cnt = CNT_W'(LAT_FADD - 1);
            OP_MUL:  rec_cnt = CNT_W'(LAT_MUL - 1);
            default: rec_cnt = CNT_W'(LAT_DIV - 1);
        endcase
    end

    hz_scoreboard #(
        .NREG (NREG),
        .CNT_W(CNT_W),
        .IDX_W(IDX_W)
    ) u_sb (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wr_en_i  (rec_en),
        .wr_idx_i (iss_dst_i),
        .wr_cnt_i (rec_cnt),
        .wr_unit_i(op),
        .tag_o    (tag),
        .cnt_o    (cnt)
    );

    assign stall_o     = hazard;
    assign bubble_o    = hazard;
    assign byp_sel_a_o = sel[0];
    assign byp_sel_b_o = sel[1];

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk
    import hz_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             iss_valid_i,
    input logic [1:0]       iss_op_i,
    input logic [IDX_W-1:0] iss_src_a_i,
    input logic [IDX_W-1:0] iss_src_b_i,
    input logic [IDX_W-1:0] iss_dst_i,
    input logic             iss_dst_wr_i,
    input logic             stall_o,
    input logic             bubble_o,
    input logic [2:0]       byp_sel_a_o,
    input logic [2:0]       byp_sel_b_o
);

    logic             prev_int_q;
    logic [IDX_W-1:0] prev_dst_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_int_q <= 1'b0;
            prev_dst_q <= '0;
        end else begin
            prev_int_q <= iss_valid_i && !stall_o && iss_dst_wr_i &&
                          (iss_op_i == OP_INT) && (iss_dst_i != '0);
            prev_dst_q <= iss_dst_i;
        end
    end

    // R9
    stall_needs_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_o |-> iss_valid_i);

    // R9
    bubble_with_stall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bubble_o |-> stall_o);

    // R6
    zero_reg_a_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (iss_src_a_i == '0) |-> (byp_sel_a_o == BYP_RF));

    // R6
    zero_reg_b_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (iss_src_b_i == '0) |-> (byp_sel_b_o == BYP_RF));

    // R3
    int_back_to_back_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (iss_valid_i && prev_int_q && (iss_src_a_i == prev_dst_q))
            |-> (byp_sel_a_o == BYP_INT));

endmodule

bind hz_interlock hz_interlock_chk #(.NREG(NREG)) u_hz_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .iss_valid_i (iss_valid_i),
    .iss_op_i    (iss_op_i),
    .iss_src_a_i (iss_src_a_i),
    .iss_src_b_i (iss_src_b_i),
    .iss_dst_i   (iss_dst_i),
    .iss_dst_wr_i(iss_dst_wr_i),
    .stall_o     (stall_o),
    .bubble_o    (bubble_o),
    .byp_sel_a_o (byp_sel_a_o),
    .byp_sel_b_o (byp_sel_b_o)
);

// File: tb/test_hz_interlock.sv
module test_hz_interlock;

    localparam logic [1:0] C_INT = 2'd0, C_FADD = 2'd1, C_MUL = 2'd2, C_DIV = 2'd3;
    localparam logic [2:0] S_RF = 3'd0, S_INT = 3'd1, S_FADD = 3'd2, S_MUL = 3'd3, S_DIV = 3'd4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid = 1'b0;
    logic [1:0] op = '0;
    logic [4:0] sa = '0, sb = '0, dst = '0;
    logic       wr = 1'b0;
    logic       stall, bubble;
    logic [2:0] sel_a, sel_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hz_interlock i_hz_interlock (
        .clk_i       (clk),
        .rst_i       (rst),
        .iss_valid_i (valid),
        .iss_op_i    (op),
        .iss_src_a_i (sa),
        .iss_src_b_i (sb),
        .iss_dst_i   (dst),
        .iss_dst_wr_i(wr),
        .stall_o     (stall),
        .bubble_o    (bubble),
        .byp_sel_a_o (sel_a),
        .byp_sel_b_o (sel_b)
    );

    // apply inputs after a falling edge, sample before the next rising edge
    task automatic drive(input logic v, input logic [1:0] c, input logic [4:0] d,
                         input logic w, input logic [4:0] a, input logic [4:0] b);
        @(negedge clk);
        valid = v; op = c; dst = d; wr = w; sa = a; sb = b;
        #1;
    endtask

    task automatic expect_out(input string req, input logic e_stall,
                              input logic [2:0] e_a, input logic [2:0] e_b);
        n_chk++;
        if (stall !== e_stall || bubble !== e_stall || sel_a !== e_a || sel_b !== e_b) begin
            n_fail++;
            $display("FAIL %s: stall=%0b bubble=%0b sel_a=%0d sel_b=%0d expected stall=%0b bubble=%0b sel_a=%0d sel_b=%0d",
                     req, stall, bubble, sel_a, sel_b, e_stall, e_stall, e_a, e_b);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, C_INT, 5'd0, 1'b0, 5'd0, 5'd0);
    endtask

    task automatic t_reset();
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd1, 5'd2);
        expect_out("R1 reset empty", 1'b0, S_RF, S_RF);
        idle(2);
    endtask

    task automatic t_int_b2b();
        drive(1'b1, C_INT, 5'd3, 1'b1, 5'd0, 5'd0);
        expect_out("R3 producer issue", 1'b0, S_RF, S_RF);
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd3, 5'd0);
        expect_out("R3 back-to-back bypass", 1'b0, S_INT, S_RF);
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd3, 5'd0);
        expect_out("R4 slot one cycle only", 1'b0, S_RF, S_RF);
        idle(2);
    endtask

    // producer with latency lat, consumer reads it on operand b from the next cycle
    task automatic t_held(input string req, input logic [1:0] c, input int lat,
                          input logic [4:0] r, input logic [2:0] slot);
        drive(1'b1, c, r, 1'b1, 5'd0, 5'd0);
        expect_out(req, 1'b0, S_RF, S_RF);
        for (int k = 1; k < lat; k++) begin
            drive(1'b1, C_INT, 5'd0, 1'b0, 5'd0, r);
            expect_out(req, 1'b1, S_RF, S_RF);
        end
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd0, r);
        expect_out(req, 1'b0, S_RF, slot);
        idle(2);
    endtask

    task automatic t_same_reg_both();
        drive(1'b1, C_FADD, 5'd14, 1'b1, 5'd0, 5'd0);
        for (int k = 1; k < 4; k++) begin
            drive(1'b1, C_INT, 5'd0, 1'b0, 5'd14, 5'd14);
            expect_out("R2 both operands wait", 1'b1, S_RF, S_RF);
        end
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd14, 5'd14);
        expect_out("R4 both operands FP slot", 1'b0, S_FADD, S_FADD);
        idle(2);
    endtask

    task automatic t_reg0();
        drive(1'b1, C_DIV, 5'd0, 1'b1, 5'd0, 5'd0);
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd0, 5'd0);
        expect_out("R6 register 0 after divide", 1'b0, S_RF, S_RF);
        idle(16);
    endtask

    task automatic t_newest();
        drive(1'b1, C_DIV, 5'd5, 1'b1, 5'd0, 5'd0);
        drive(1'b1, C_INT, 5'd5, 1'b1, 5'd0, 5'd0);
        expect_out("R7 younger writer issues", 1'b0, S_RF, S_RF);
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd5, 5'd0);
        expect_out("R7 newest producer bypass", 1'b0, S_INT, S_RF);
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd5, 5'd0);
        expect_out("R7 older divide forgotten", 1'b0, S_RF, S_RF);
        idle(16);
    endtask

    task automatic t_dual();
        drive(1'b1, C_MUL, 5'd6, 1'b1, 5'd0, 5'd0);
        drive(1'b1, C_FADD, 5'd7, 1'b1, 5'd0, 5'd0);
        for (int k = 2; k < 5; k++) begin
            drive(1'b1, C_INT, 5'd0, 1'b0, 5'd6, 5'd7);
            expect_out("R8 waiting on two", 1'b1, S_RF, S_RF);
        end
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd6, 5'd7);
        expect_out("R8 two slots same cycle", 1'b0, S_MUL, S_FADD);
        idle(2);
    endtask

    task automatic t_no_record();
        drive(1'b1, C_MUL, 5'd8, 1'b1, 5'd0, 5'd0);
        drive(1'b0, C_INT, 5'd0, 1'b0, 5'd8, 5'd0);
        expect_out("R9 invalid slot no stall", 1'b0, S_RF, S_RF);
        idle(6);
        drive(1'b1, C_MUL, 5'd13, 1'b0, 5'd0, 5'd0);
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd13, 5'd0);
        expect_out("R9 no write flag no entry", 1'b0, S_RF, S_RF);
        idle(2);
        drive(1'b1, C_MUL, 5'd9, 1'b1, 5'd0, 5'd0);
        drive(1'b1, C_INT, 5'd10, 1'b1, 5'd9, 5'd0);
        expect_out("R9 held instruction", 1'b1, S_RF, S_RF);
        drive(1'b1, C_INT, 5'd0, 1'b0, 5'd10, 5'd0);
        expect_out("R9 stalled writer recorded nothing", 1'b0, S_RF, S_RF);
        idle(6);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_int_b2b();
        t_held("R2 R5 multiply held", C_MUL, 5, 5'd4, S_MUL);
        t_held("R2 R5 fp add held", C_FADD, 4, 5'd11, S_FADD);
        t_held("R2 R5 divide held", C_DIV, 14, 5'd12, S_DIV);
        t_same_reg_both();
        t_reg0();
        t_newest();
        t_dual();
        t_no_record();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule